// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words. The write side and the read side each have their own clock. The two clocks may be one net or may be fully unrelated. Storage is an inferred array of 2^ADDR_W words. Four active-low status flags are produced. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. Pointers cross between the domains as Gray code through two-flop synchronisers, and each pointer carries one extra wrap bit.

The write side has a primary enable and a second pin whose role is latched while reset is held. If that pin is high during reset, it acts as a second write enable. If it is low during reset, it becomes a load strobe for the two threshold offsets. Driving it low then writes the offsets, or reads them back on the data output, in a fixed alternating order. Both offsets return to seven on every reset. An output-enable input either lets the read register drive the output bus or marks the bus undriven. The undriven state stands in for high impedance.

Each side is controlled by a small state machine. Write side: WR_HOLD (reset just released) goes to WR_DUAL_EN when the sampled pin was high, or to WR_LOAD_AE when it was low. WR_LOAD_AE goes to WR_LOAD_AF on an offset load, and WR_LOAD_AF goes back to WR_LOAD_AE on the next load. WR_DUAL_EN has no exits. Read side: RD_HOLD goes to RD_PLAIN or to RD_SHOW_AE. RD_SHOW_AE goes to RD_SHOW_AF on an offset read-back, and RD_SHOW_AF goes back to RD_SHOW_AE on the next one. Each side spends one clock in its HOLD state after its synchronised reset releases. No word moves during that clock.

Top module: `dcfifo_pflag`

## Requirements
- R1: In second-enable mode, a word is stored on a write-clock edge only when wr_en1_n is 0 and wr_en2_ld is 1. With wr_en2_ld at 0, nothing is stored and no offset changes.
- R2: full_n is 0 when 2^ADDR_W words are held. Write attempts while full_n is 0 store nothing.
- R3: A word is taken on a read-clock edge only when rd_en1_n and rd_en2_n are both 0. Read attempts while empty_n is 0 take nothing.
- R4: In offset-load mode, a word is stored when wr_en1_n is 0 and wr_en2_ld is 1.
- R5: The mode is set by the level of wr_en2_ld while reset is held: 1 selects second-enable mode and 0 selects offset-load mode. Changes on the pin after reset do not change the mode.
- R6: While rst_n is 0 and after reset: pointers are zero, empty_n and aempty_n are 0, full_n and afull_n are 1, both offsets are 7, and the read register holds 0.
- R7: aempty_n is 0 exactly when the fill level is at or below the almost-empty offset.
- R8: afull_n is 0 exactly when the fill level is at or above 2^ADDR_W minus the almost-full offset.
- R9: In offset-load mode, each write-clock edge with wr_en2_ld at 0 and wr_en1_n at 0 loads wr_data[ADDR_W-1:0]. Loads go to the almost-empty offset first, then the almost-full offset, and keep alternating.
- R10: In offset-load mode, each read-clock edge with wr_en2_ld at 0 and both read enables at 0 places the next offset, zero-extended to 9 bits, on rd_q. The order is almost-empty first, then alternating. No word is taken from the FIFO.
- R11: While out_en_n is 1, rd_q_oe is 0 and rd_q is 0. While out_en_n is 0, rd_q_oe is 1 and rd_q shows the read register.
- R12: Words leave in the order they were stored. A taken word appears on rd_q after the read edge that takes it.
- R13: Each pointer changes by at most one Gray bit per clock. Every flag reaches its settled value within three edges of its own clock after the opposite side goes quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release per domain |
| wr_data | input | 9 | Write word; low ADDR_W bits also carry offset values |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or offset load strobe (role latched in reset) |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_q | output | 9 | Read data, 0 while undriven |
| rd_q_oe | output | 1 | 1 when rd_q is driven, 0 for high impedance |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
The hardest state to reach is offset-load mode with non-default thresholds and data already stored. Getting there takes a reset with the strobe pin held low, then a series of loads. Read-back must then be interleaved with stored words, without any read-back being mistaken for a pop. The stimulus makes a directed pass for this: loads, read-back across both alternation phases, then single-word writes. After each write the bench lets the design settle and checks both thresholds. Separately, a full sweep of fill levels from 0 to capacity, with one write attempt past full, covers the flag boundaries. A seeded random mix of enables and output-enable then exercises ordering and the enable qualification.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic [1:0] {
        WR_HOLD,
        WR_DUAL_EN,
        WR_LOAD_AE,
        WR_LOAD_AF
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_HOLD,
        RD_PLAIN,
        RD_SHOW_AE,
        RD_SHOW_AF
    } rd_state_t;

endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= 1'b0;
            srst_n <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            srst_n <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int OFS_DEF = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en1_n,
    input  logic              en2_ld,
    input  logic [ADDR_W-1:0] ofs_din,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              push,
    output logic [ADDR_W:0]   wr_bin,
    output logic [ADDR_W:0]   wr_gray,
    output logic              full_n,
    output logic              afull_n,
    output logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] af_ofs
);
    localparam logic [ADDR_W:0]   DEPTH_P  = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W-1:0] OFS_INIT = OFS_DEF[ADDR_W-1:0];

    wr_state_t         state, nxt;
    logic              mode_q;
    logic              load_mode, ofs_wr;
    logic [ADDR_W:0]   bin_nxt, rd_bin_s, fill, thresh;

    // pin level captured while the synchronised reset is still low
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= en2_ld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        load_mode = (state == WR_LOAD_AE) || (state == WR_LOAD_AF);
        ofs_wr    = load_mode && !en2_ld && !en1_n;
        push      = (state != WR_HOLD) && !en1_n && en2_ld && full_n;
        nxt       = state;
        unique case (state)
            WR_HOLD:    nxt = mode_q ? WR_DUAL_EN : WR_LOAD_AE;
            WR_DUAL_EN: nxt = WR_DUAL_EN;
            WR_LOAD_AE: if (ofs_wr) nxt = WR_LOAD_AF;
            WR_LOAD_AF: if (ofs_wr) nxt = WR_LOAD_AE;
        endcase
    end

    always_comb begin
        for (int i = 0; i <= ADDR_W; i++) rd_bin_s[i] = ^(rd_gray_s >> i);
        bin_nxt = wr_bin + {{ADDR_W{1'b0}}, push};
        fill    = bin_nxt - rd_bin_s;
        thresh  = DEPTH_P - {1'b0, af_ofs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
            ae_ofs  <= OFS_INIT;
            af_ofs  <= OFS_INIT;
        end else begin
            wr_bin  <= bin_nxt;
            wr_gray <= bin_nxt ^ (bin_nxt >> 1);
            full_n  <= (fill != DEPTH_P);
            afull_n <= !(fill >= thresh);
            if (ofs_wr && state == WR_LOAD_AE) ae_ofs <= ofs_din;
            if (ofs_wr && state == WR_LOAD_AF) af_ofs <= ofs_din;
        end
    end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_pin,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic [ADDR_W-1:0] af_ofs,
    input  logic [DATA_W-1:0] mem_q,
    output logic              pop,
    output logic [ADDR_W:0]   rd_bin,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PAD = DATA_W - ADDR_W;

    rd_state_t       state, nxt;
    logic            mode_q;
    logic            load_mode, ld_low, both, ofs_rd;
    logic [ADDR_W:0] bin_nxt, wr_bin_s, fill;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ld_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        load_mode = (state == RD_SHOW_AE) || (state == RD_SHOW_AF);
        ld_low    = load_mode && !ld_pin;
        both      = !ren1_n && !ren2_n;
        ofs_rd    = ld_low && both;
        pop       = (state != RD_HOLD) && both && !ld_low && empty_n;
        nxt       = state;
        unique case (state)
            RD_HOLD:    nxt = mode_q ? RD_PLAIN : RD_SHOW_AE;
            RD_PLAIN:   nxt = RD_PLAIN;
            RD_SHOW_AE: if (ofs_rd) nxt = RD_SHOW_AF;
            RD_SHOW_AF: if (ofs_rd) nxt = RD_SHOW_AE;
        endcase
    end

    always_comb begin
        for (int i = 0; i <= ADDR_W; i++) wr_bin_s[i] = ^(wr_gray_s >> i);
        bin_nxt = rd_bin + {{ADDR_W{1'b0}}, pop};
        fill    = wr_bin_s - bin_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin   <= '0;
            rd_gray  <= '0;
            q        <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rd_bin   <= bin_nxt;
            rd_gray  <= bin_nxt ^ (bin_nxt >> 1);
            empty_n  <= (fill != '0);
            aempty_n <= !(fill <= {1'b0, ae_ofs});
            if (pop)
                q <= mem_q;
            else if (ofs_rd)
                q <= (state == RD_SHOW_AE) ? {{PAD{1'b0}}, ae_ofs} : {{PAD{1'b0}}, af_ofs};
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 9,
    parameter int OFS_DEF = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_q,
    output logic              rd_q_oe,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              full_n,
    output logic              afull_n
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              wr_srst_n, rd_srst_n;
    logic              push, pop;
    logic [ADDR_W:0]   wr_bin, wr_gray, rd_bin, rd_gray;
    logic [ADDR_W:0]   wr_gray_s, rd_gray_s;
    logic [ADDR_W-1:0] ae_ofs, af_ofs;
    logic [DATA_W-1:0] mem_q, q_reg;
    logic [DATA_W-1:0] mem [DEPTH];

    dcfifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
    dcfifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

    dcfifo_gray_sync #(.W(ADDR_W + 1)) u_rd2wr (
        .clk(wr_clk), .rst_n(wr_srst_n), .d(rd_gray), .q(rd_gray_s)
    );
    dcfifo_gray_sync #(.W(ADDR_W + 1)) u_wr2rd (
        .clk(rd_clk), .rst_n(rd_srst_n), .d(wr_gray), .q(wr_gray_s)
    );

    dcfifo_wr_ctl #(.ADDR_W(ADDR_W), .OFS_DEF(OFS_DEF)) u_wr (
        .clk(wr_clk), .rst_n(wr_srst_n), .en1_n(wr_en1_n), .en2_ld(wr_en2_ld),
        .ofs_din(wr_data[ADDR_W-1:0]), .rd_gray_s(rd_gray_s), .push(push),
        .wr_bin(wr_bin), .wr_gray(wr_gray), .full_n(full_n), .afull_n(afull_n),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcfifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_srst_n), .ld_pin(wr_en2_ld), .ren1_n(rd_en1_n),
        .ren2_n(rd_en2_n), .wr_gray_s(wr_gray_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .mem_q(mem_q), .pop(pop), .rd_bin(rd_bin), .rd_gray(rd_gray), .q(q_reg),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    always_ff @(posedge wr_clk) begin
        if (push) mem[wr_bin[ADDR_W-1:0]] <= wr_data;
    end

    assign mem_q   = mem[rd_bin[ADDR_W-1:0]];
    assign rd_q    = out_en_n ? '0 : q_reg;
    assign rd_q_oe = !out_en_n;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
    parameter int ADDR_W = 4
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst_n,
    input logic            full_n,
    input logic            afull_n,
    input logic            empty_n,
    input logic            aempty_n,
    input logic [ADDR_W:0] wr_bin,
    input logic [ADDR_W:0] rd_bin,
    input logic [ADDR_W:0] wr_gray,
    input logic [ADDR_W:0] rd_gray
);
    // R2
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wr_bin));

    // R3
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_bin));

    // R8
    full_in_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R7
    empty_in_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R13
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(wr_gray ^ $past(wr_gray)));

    // R13
    rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .full_n(full_n),
    .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n), .wr_bin(wr_bin),
    .rd_bin(rd_bin), .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/dcfifo_pflag_bench.sv
module dcfifo_pflag_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rd_clk;
    logic       rst_n = 1'b0;
    logic [8:0] wr_data = '0;
    logic       wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
    logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
    logic [8:0] rd_q;
    logic       rd_q_oe, empty_n, aempty_n, full_n, afull_n;

    int vectors = 0, misses = 0;
    bit done = 0;

    logic [8:0]    model_q[$];
    logic [8:0]    last_q;
    logic [AW-1:0] m_ae, m_af;
    bit            ofs_mode, sel_w, sel_r;

    always #4 clk = ~clk;
    assign rd_clk = clk;

    dcfifo_pflag u_dcfifo_pflag (
        .wr_clk(clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .rd_q(rd_q), .rd_q_oe(rd_q_oe),
        .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
    );

    task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_aempty_n(int c);
        return !(c <= int'(m_ae));
    endfunction

    function automatic logic exp_afull_n(int c);
        return !(c >= DEPTH - int'(m_af));
    endfunction

    // one cycle: drive at negedge, let one edge act, check at the next negedge
    task automatic step(logic w1n, logic w2, logic r1n, logic r2n, logic oen, logic [8:0] d);
        logic push, pop, ldw, ldr, ldlow;
        wr_en1_n = w1n; wr_en2_ld = w2; rd_en1_n = r1n; rd_en2_n = r2n;
        out_en_n = oen; wr_data = d;
        ldlow = ofs_mode && !w2;
        push  = !w1n && w2 && full_n;
        ldw   = ldlow && !w1n;
        ldr   = ldlow && !r1n && !r2n;
        pop   = !r1n && !r2n && !ldlow && empty_n;
        @(posedge clk);
        @(negedge clk);
        if (push) model_q.push_back(d);
        if (ldw) begin
            if (!sel_w) m_ae = d[AW-1:0]; else m_af = d[AW-1:0];
            sel_w = !sel_w;
        end
        if (pop) last_q = model_q.pop_front();
        if (ldr) begin
            last_q = sel_r ? {5'd0, m_af} : {5'd0, m_ae};
            sel_r  = !sel_r;
        end
        if (!oen) begin
            chk(ldr ? "R10 readback" : "R12 data", rd_q, last_q);
            chk("R11 oe driven", {8'd0, rd_q_oe}, 9'd1);
        end else begin
            chk("R11 hiz data", rd_q, 9'd0);
            chk("R11 hiz oe", {8'd0, rd_q_oe}, 9'd0);
        end
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'd0);
    endtask

    // R13: flags settled after quiet cycles; R2 R7 R8 boundaries
    task automatic settle_check(string tag);
        int c;
        repeat (6) idle();
        c = model_q.size();
        chk({tag, " R13 empty_n"},  {8'd0, empty_n},  {8'd0, c != 0});
        chk({tag, " R7 aempty_n"},  {8'd0, aempty_n}, {8'd0, exp_aempty_n(c)});
        chk({tag, " R2 full_n"},    {8'd0, full_n},   {8'd0, c != DEPTH});
        chk({tag, " R8 afull_n"},   {8'd0, afull_n},  {8'd0, exp_afull_n(c)});
    endtask

    task automatic do_reset(logic pin);
        @(negedge clk);
        rst_n = 1'b0; wr_en2_ld = pin; wr_en1_n = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1; out_en_n = 1'b0;
        repeat (3) @(negedge clk);
        // R6: state while reset held
        chk("R6 empty_n", {8'd0, empty_n}, 9'd0);
        chk("R6 aempty_n", {8'd0, aempty_n}, 9'd0);
        chk("R6 full_n", {8'd0, full_n}, 9'd1);
        chk("R6 afull_n", {8'd0, afull_n}, 9'd1);
        chk("R6 rd_q", rd_q, 9'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        model_q.delete();
        last_q = '0; m_ae = 4'd7; m_af = 4'd7;
        sel_w = 0; sel_r = 0; ofs_mode = !pin;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // second-enable mode
        do_reset(1'b1);
        settle_check("R6 after reset");
        // R5: pin driven low after reset must not switch to offset mode; R1 no write
        repeat (3) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h00B);
        settle_check("R1 R5 en2 low");
        // sweep every fill level (thresholds stay at 7 proves no offset load, R1)
        for (int i = 0; i <= DEPTH; i++) begin
            settle_check("R1 R7 R8 sweep");
            step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'(i * 29 + 5));
        end
        settle_check("R2 full hold");
        // R3 read with a single enable takes nothing
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'd0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'd0);
        settle_check("R3 one enable");
        // drain, with output disabled for part (R11), past empty (R3)
        for (int i = 0; i < DEPTH + 2; i++)
            step(1'b1, 1'b1, 1'b0, 1'b0, logic'(i % 5 == 2), 9'd0);
        settle_check("R3 R12 drained");

        // random mix in second-enable mode
        for (int n = 0; n < 3000; n++) begin
            step(logic'($urandom % 3 == 0), logic'($urandom % 6 != 0),
                 logic'($urandom % 4 == 0), logic'($urandom % 5 == 0),
                 logic'($urandom % 7 == 0), 9'($urandom));
            if (n % 250 == 249) settle_check("R12 random");
        end

        // offset-load mode
        do_reset(1'b0);
        settle_check("R6 ofs reset");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h1F3);  // R9: almost-empty offset 3
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0AC);  // R9: almost-full offset 12
        settle_check("R9 loaded");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0);  // R10
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'(i + 9'h140));  // R4
            settle_check("R4 R7 R8 ofs");
        end
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0);  // R10: readback leaves count
        settle_check("R10 no pop");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0);
        settle_check("R12 ofs drained");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule